// File: doc/BRIEF.md
# Compressed Block Address Translation Buffer

This block sits in an instruction fetch path whose program image is stored compressed. Control flow computes the original, uncompressed start address of a basic block. The fetch unit must then learn where that block lives in compressed memory and how to fetch it. The block keeps a small, fully associative cache of translation entries for that purpose. Each entry is tagged by an original block address. It holds the block's compressed start address, resolved to the single bit because compressed blocks may begin anywhere inside a byte. It also holds the number of memory lines covering the block, the number of issue groups in the block, the program-counter offset of the block's final operation and a predicted address for the following fetch block.

A lookup is presented with a valid level and an address. It completes in the same cycle when the entry is resident. On a miss, the block sends one refill request to a larger backing translation table and stalls the lookup. It then installs the returned entry, replacing entries in round-robin order, and answers the stalled lookup from the returned data in the same cycle the entry arrives. A single-cycle invalidate input empties the buffer, for example after a new program image has been loaded.

Top module: `blk_xlate_buf`

## Requirements
- R1: After reset no entry is valid: `lk_ready` and `rf_req_valid` are low while `lk_valid` is low, and the first lookup of any address misses.
- R2: A lookup whose address matches a valid entry raises `lk_ready` in the same cycle as `lk_valid` and drives all five stored fields on the response outputs.
- R3: A missing lookup raises `rf_req_valid` for exactly one cycle, with `rf_req_addr` equal to the lookup address. No further request is made while that refill is outstanding, and no request is made on a hit.
- R4: While a refill is outstanding and no refill response is present, `lk_ready` stays low for the stalled lookup.
- R5: In the cycle `rf_rsp_valid` is high with `rf_rsp_tag` equal to the stalled lookup address, `lk_ready` is high and the response outputs carry the refill fields.
- R6: Once installed, an entry hits on later lookups of its tag until it is evicted or invalidated.
- R7: The compressed address is a bit address. Its three least significant bits (the bit position within a byte) are stored and returned unchanged.
- R8: The buffer holds 16 entries. Each refill of a tag that is not resident goes into the slot named by a round-robin pointer, which then advances. After 16 distinct tags, the seventeenth displaces the earliest installed one.
- R9: A refill response whose tag is already resident overwrites that entry's fields in place. No other entry is disturbed and the replacement pointer does not advance.
- R10: A one-cycle pulse on `inv_all` invalidates every entry, so a lookup in any later cycle misses.
- R11: `lk_ready` is never high while `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | 32 | Original block start address to translate |
| lk_ready | output | 1 | Lookup answered this cycle |
| rsp_cbit_addr | output | 32 | Compressed start address in bits |
| rsp_lines | output | 3 | Memory lines to fetch for the block |
| rsp_groups | output | 4 | Issue groups in the block |
| rsp_last_ofs | output | 5 | PC offset of the block's last operation |
| rsp_next_pc | output | 32 | Predicted next fetch block address |
| rf_req_valid | output | 1 | Refill request pulse |
| rf_req_addr | output | 32 | Address whose entry is requested |
| rf_rsp_valid | input | 1 | Refill entry delivered |
| rf_rsp_tag | input | 32 | Original address of the delivered entry |
| rf_rsp_cbit_addr | input | 32 | Delivered compressed bit address |
| rf_rsp_lines | input | 3 | Delivered line count |
| rf_rsp_groups | input | 4 | Delivered issue-group count |
| rf_rsp_last_ofs | input | 5 | Delivered last-operation offset |
| rf_rsp_next_pc | input | 32 | Delivered next-block prediction |

## Verification
The assertions assume that a lookup, once raised, keeps `lk_valid` high and `lk_addr` unchanged until `lk_ready`. They also assume that the backing table answers an outstanding request before any new lookup is issued. The stimulus follows both rules: each lookup is driven by a task that holds the address through the stall and serves its own refill after a random latency of zero to three cycles. Unsolicited refill responses used to exercise in-place overwrite are sent only while no lookup is active. Random addresses come from a pool of 24 tags, larger than the buffer, so that hits, evictions and invalidations interleave.

// File: rtl/blk_xlate_pkg.sv
// Shared widths and entry layout for the compressed block translation buffer.
// Assumes the compressed space is addressed in bits.
package blk_xlate_pkg;
    localparam int OA_W = 32;  // original address width
    localparam int CB_W = 32;  // compressed bit address width
    localparam int LN_W = 3;   // memory line count width
    localparam int GR_W = 4;   // issue group count width
    localparam int OF_W = 5;   // last-operation offset width

    typedef struct packed {
        logic [CB_W-1:0] cbit;
        logic [LN_W-1:0] lines;
        logic [GR_W-1:0] groups;
        logic [OF_W-1:0] last_ofs;
        logic [OA_W-1:0] next_pc;
    } xl_entry_t;
endpackage

// File: rtl/blk_xlate_victim.sv
// Round-robin replacement pointer. Advances by one slot each time a new tag
// is installed and wraps after the last slot. Assumes ENTRIES >= 2.
module blk_xlate_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] ptr_q;

    // Step the pointer on each fresh install, wrapping at ENTRIES-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end

    assign victim_idx = ptr_q;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr_q) < ENTRIES); // R8
    AST_PTR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q)); // R9
endmodule

// File: rtl/blk_xlate_cam.sv
// Fully associative tag store with payload. Provides a lookup match and a
// separate write match so that a refill of a resident tag rewrites that slot.
// Assumes the write port never creates duplicate tags (guaranteed by wr_hit).
module blk_xlate_cam
    import blk_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [OA_W-1:0]  lk_addr,
    output logic             lk_hit,
    output xl_entry_t        lk_data,
    input  logic             wr_en,
    input  logic [OA_W-1:0]  wr_tag,
    input  xl_entry_t        wr_data,
    input  logic [IDX_W-1:0] victim_idx,
    output logic             wr_hit
);
    logic [ENTRIES-1:0] vld_q;
    logic [OA_W-1:0]    tag_q [ENTRIES];
    xl_entry_t          pay_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match, wr_match;
    logic [IDX_W-1:0]   lk_idx, wr_hit_idx, wr_idx;

    // One comparator pair per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_addr);
        assign wr_match[g] = vld_q[g] && (tag_q[g] == wr_tag);
    end

    // Encode the one-hot match vectors into slot indices.
    always_comb begin
        lk_idx     = '0;
        wr_hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_idx     = IDX_W'(i);
            if (wr_match[i]) wr_hit_idx = IDX_W'(i);
        end
    end

    assign lk_hit  = |lk_match;
    assign lk_data = pay_q[lk_idx];
    assign wr_hit  = |wr_match;
    assign wr_idx  = wr_hit ? wr_hit_idx : victim_idx;

    // Valid bits: invalidate-all first, then a same-cycle install survives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else begin
            if (inv_all) vld_q <= '0;
            if (wr_en)   vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and payload storage; contents are qualified by the valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            pay_q[wr_idx] <= wr_data;
        end
    end

    AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R9
    AST_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !wr_en) |=> (vld_q == '0)); // R10
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]); // R6
endmodule

// File: rtl/blk_xlate_buf.sv
// Top of the compressed block translation buffer. Combinational lookup into
// the tag store; a miss issues a single refill request, stalls, installs the
// returned entry and answers from the refill data in its arrival cycle.
// Assumes the requester holds lk_valid/lk_addr until lk_ready.
module blk_xlate_buf
    import blk_xlate_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inv_all,
    input  logic            lk_valid,
    input  logic [OA_W-1:0] lk_addr,
    output logic            lk_ready,
    output logic [CB_W-1:0] rsp_cbit_addr,
    output logic [LN_W-1:0] rsp_lines,
    output logic [GR_W-1:0] rsp_groups,
    output logic [OF_W-1:0] rsp_last_ofs,
    output logic [OA_W-1:0] rsp_next_pc,
    output logic            rf_req_valid,
    output logic [OA_W-1:0] rf_req_addr,
    input  logic            rf_rsp_valid,
    input  logic [OA_W-1:0] rf_rsp_tag,
    input  logic [CB_W-1:0] rf_rsp_cbit_addr,
    input  logic [LN_W-1:0] rf_rsp_lines,
    input  logic [GR_W-1:0] rf_rsp_groups,
    input  logic [OF_W-1:0] rf_rsp_last_ofs,
    input  logic [OA_W-1:0] rf_rsp_next_pc
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic             cam_hit, wr_hit, bypass, pending_q;
    logic [IDX_W-1:0] victim_idx;
    xl_entry_t        cam_data, fill_data, out_data;

    assign fill_data = '{cbit: rf_rsp_cbit_addr, lines: rf_rsp_lines,
                         groups: rf_rsp_groups, last_ofs: rf_rsp_last_ofs,
                         next_pc: rf_rsp_next_pc};

    blk_xlate_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_addr(lk_addr), .lk_hit(cam_hit), .lk_data(cam_data),
        .wr_en(rf_rsp_valid), .wr_tag(rf_rsp_tag), .wr_data(fill_data),
        .victim_idx(victim_idx), .wr_hit(wr_hit)
    );

    blk_xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .adv(rf_rsp_valid && !wr_hit),
        .victim_idx(victim_idx)
    );

    // Refill data arriving for the looked-up tag takes precedence.
    assign bypass   = rf_rsp_valid && (rf_rsp_tag == lk_addr);
    assign out_data = bypass ? fill_data : cam_data;
    assign lk_ready = lk_valid && (cam_hit || bypass);

    assign rsp_cbit_addr = out_data.cbit;
    assign rsp_lines     = out_data.lines;
    assign rsp_groups    = out_data.groups;
    assign rsp_last_ofs  = out_data.last_ofs;
    assign rsp_next_pc   = out_data.next_pc;

    assign rf_req_valid = lk_valid && !cam_hit && !bypass && !pending_q;
    assign rf_req_addr  = lk_addr;

    // Track the single outstanding refill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (rf_rsp_valid)
            pending_q <= 1'b0;
        else if (rf_req_valid)
            pending_q <= 1'b1;
    end

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> lk_valid); // R11
    AST_NO_REQ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req_valid |-> !lk_ready); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !rf_req_valid); // R3
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_addr))); // R4
    AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !rf_rsp_valid && lk_valid && !cam_hit) |-> !lk_ready); // R4
endmodule

// File: tb/blk_xlate_buf_test.sv
module blk_xlate_buf_test;
    import blk_xlate_pkg::*;

    logic clk = 0, rst_n = 0, inv_all = 0, lk_valid = 0, rf_rsp_valid = 0;
    logic [OA_W-1:0] lk_addr = '0, rf_rsp_tag = '0, rf_rsp_next_pc = '0;
    logic [CB_W-1:0] rf_rsp_cbit_addr = '0;
    logic [LN_W-1:0] rf_rsp_lines = '0;
    logic [GR_W-1:0] rf_rsp_groups = '0;
    logic [OF_W-1:0] rf_rsp_last_ofs = '0;
    logic lk_ready, rf_req_valid;
    logic [CB_W-1:0] rsp_cbit_addr;
    logic [LN_W-1:0] rsp_lines;
    logic [GR_W-1:0] rsp_groups;
    logic [OF_W-1:0] rsp_last_ofs;
    logic [OA_W-1:0] rsp_next_pc, rf_req_addr;

    int tests = 0, fails = 0;
    logic [31:0] m_tag [16];
    logic [3:0]  m_salt [16];
    bit          m_vld [16];
    int          m_rr = 0;
    bit          last_hit;

    always #4 clk = ~clk;

    blk_xlate_buf uut (.*);

    function automatic logic [31:0] pool(int i);
        return 32'h0040_0000 + 32'(i) * 32'd24 + 32'(i % 5);
    endfunction
    function automatic logic [CB_W-1:0] e_cbit(logic [31:0] a, logic [3:0] s);
        return {a[28:0] ^ {25'd0, s}, 3'(a[6:4] + 3'(s))};
    endfunction
    function automatic logic [LN_W-1:0] e_lines(logic [31:0] a, logic [3:0] s);
        return 3'(a[3:1] + 3'(s));
    endfunction
    function automatic logic [GR_W-1:0] e_groups(logic [31:0] a, logic [3:0] s);
        return a[7:4] ^ s;
    endfunction
    function automatic logic [OF_W-1:0] e_ofs(logic [31:0] a, logic [3:0] s);
        return 5'(a[8:4] + 5'(s));
    endfunction
    function automatic logic [OA_W-1:0] e_next(logic [31:0] a, logic [3:0] s);
        return a + 32'd40 + 32'(s) * 32'd8;
    endfunction
    function automatic int m_find(logic [31:0] a);
        for (int i = 0; i < 16; i++) if (m_vld[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic chk_data(input logic [31:0] a, input logic [3:0] s, input string req);
        chk(rsp_cbit_addr == e_cbit(a, s), {req, " cbit"}, 64'(rsp_cbit_addr), 64'(e_cbit(a, s)));
        chk(rsp_cbit_addr[2:0] == e_cbit(a, s)[2:0], "R7 sub-byte bits", 64'(rsp_cbit_addr[2:0]), 64'(e_cbit(a, s)[2:0]));
        chk(rsp_lines == e_lines(a, s), {req, " lines"}, 64'(rsp_lines), 64'(e_lines(a, s)));
        chk(rsp_groups == e_groups(a, s), {req, " groups"}, 64'(rsp_groups), 64'(e_groups(a, s)));
        chk(rsp_last_ofs == e_ofs(a, s), {req, " last_ofs"}, 64'(rsp_last_ofs), 64'(e_ofs(a, s)));
        chk(rsp_next_pc == e_next(a, s), {req, " next_pc"}, 64'(rsp_next_pc), 64'(e_next(a, s)));
    endtask

    task automatic drive_rsp(input logic [31:0] a, input logic [3:0] s);
        rf_rsp_valid = 1; rf_rsp_tag = a;
        rf_rsp_cbit_addr = e_cbit(a, s); rf_rsp_lines = e_lines(a, s);
        rf_rsp_groups = e_groups(a, s); rf_rsp_last_ofs = e_ofs(a, s);
        rf_rsp_next_pc = e_next(a, s);
    endtask

    task automatic m_install(input logic [31:0] a, input logic [3:0] s);
        int k = m_find(a);
        if (k >= 0) m_salt[k] = s;
        else begin
            m_tag[m_rr] = a; m_salt[m_rr] = s; m_vld[m_rr] = 1;
            m_rr = (m_rr + 1) % 16;
        end
    endtask

    task automatic do_lookup(input logic [31:0] a);
        int k = m_find(a);
        logic [3:0] s;
        int lat;
        @(negedge clk); lk_valid = 1; lk_addr = a; #1;
        last_hit = lk_ready;
        if (k >= 0) begin
            chk(lk_ready, "R2 ready on hit", 64'(lk_ready), 1);
            chk(!rf_req_valid, "R3 no request on hit", 64'(rf_req_valid), 0);
            chk_data(a, m_salt[k], "R2");
        end else begin
            chk(!lk_ready, "R4 stall on miss", 64'(lk_ready), 0);
            chk(rf_req_valid && rf_req_addr == a, "R3 request", 64'(rf_req_addr), 64'(a));
            lat = $urandom_range(0, 3);
            for (int j = 0; j < lat; j++) begin
                @(negedge clk); #1;
                chk(!lk_ready, "R4 stall held", 64'(lk_ready), 0);
                chk(!rf_req_valid, "R3 single request", 64'(rf_req_valid), 0);
            end
            @(negedge clk);
            s = 4'($urandom_range(0, 15));
            drive_rsp(a, s); #1;
            chk(lk_ready, "R5 ready on refill", 64'(lk_ready), 1);
            chk_data(a, s, "R5");
            m_install(a, s);
        end
        @(negedge clk); lk_valid = 0; rf_rsp_valid = 0; #1;
        chk(!lk_ready, "R11 idle not ready", 64'(lk_ready), 0);
    endtask

    task automatic do_flush();
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        for (int i = 0; i < 16; i++) m_vld[i] = 0;
    endtask

    task automatic do_overwrite(input logic [31:0] a, input logic [3:0] s);
        @(negedge clk); drive_rsp(a, s);
        @(negedge clk); rf_rsp_valid = 0;
        m_install(a, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < 16; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(!lk_ready && !rf_req_valid, "R1 idle after reset", {lk_ready, rf_req_valid}, 0);
        do_lookup(pool(0));
        chk(!last_hit, "R1 first lookup misses", 64'(last_hit), 0);
        do_lookup(pool(0));
        chk(last_hit, "R6 installed entry hits", 64'(last_hit), 1);
        for (int i = 1; i < 16; i++) do_lookup(pool(i));
        for (int i = 0; i < 16; i++) begin
            do_lookup(pool(i));
            chk(last_hit, "R8 all 16 resident", 64'(last_hit), 1);
        end
        do_lookup(pool(16));
        do_lookup(pool(1));
        chk(last_hit, "R8 second entry kept", 64'(last_hit), 1);
        do_lookup(pool(0));
        chk(!last_hit, "R8 oldest evicted", 64'(last_hit), 0);
        do_overwrite(pool(5), 4'hA);
        do_lookup(pool(5));
        chk(last_hit, "R9 overwrite in place hits", 64'(last_hit), 1);
        do_lookup(pool(3));
        chk(last_hit, "R9 neighbour kept", 64'(last_hit), 1);
        do_lookup(pool(17));
        do_lookup(pool(2));
        chk(!last_hit, "R9 pointer did not advance", 64'(last_hit), 0);
        do_flush();
        do_lookup(pool(3));
        chk(!last_hit, "R10 invalidated", 64'(last_hit), 0);
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) do_flush();
            else if (r < 8) do_overwrite(pool($urandom_range(0, 23)), 4'($urandom_range(0, 15)));
            else do_lookup(pool($urandom_range(0, 23)));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule